// File: doc/BRIEF.md
# Table-Driven Multi-Block DMA Channel

This block is a single DMA channel that copies several unrelated memory regions in one run. Software does not program each region itself. It builds a table of descriptors in memory, loads a pointer to that table and the number of descriptors through a small register port, and sets an enable bit. The channel fetches each descriptor byte by byte through a dedicated table read port. It then moves the described bytes through a byte-wide data port and steps to the next descriptor. When the last descriptor is finished, it reports completion.

Two layouts are supported. In two-address mode each descriptor carries a source address, a destination address and a byte count. In single-cycle I/O mode the destination is an I/O port, so the descriptor drops the destination field. Each fetched byte is then handed to the I/O strobe rather than written back to memory. This mode gives a shorter table and fewer fetch reads per block.

Top module: `chain_dma_top`

## Requirements
- R1: Register writes on the configuration port load the table pointer (address 0) and the block counter (address 1). Both are visible on `tbl_ptr` and `blocks_left`. Writes to any address are ignored while the channel is enabled or busy.
- R2: A write to address 2 with bit 0 set starts the channel only if the table pointer is even, and it clears `start_err`. With an odd pointer, `start_err` is set, `chan_en` stays 0, and no table or data cycles occur. Bit 1 of the same write selects single-cycle I/O mode (1) or two-address mode (0).
- R3: In two-address mode, a descriptor is three 4-byte slots at the pointer: source at +0, destination at +4, count at +8. Each value is 24 bits, stored low byte first in the slot's first three bytes. Exactly 9 table reads are made per descriptor, and table data returns one cycle after `tbl_rd_en`.
- R4: In single-cycle I/O mode, a descriptor is two slots: source at +0 and count at +4. Exactly 6 table reads are made per descriptor.
- R5: In two-address mode, byte i of a block is read from source+i. In the following cycle it is written to destination+i with the data read. Bytes are handled in ascending order.
- R6: In single-cycle I/O mode, byte i is read from source+i. In the following cycle `io_wr_en` pulses with that data on `io_wdata`. `mem_wr_en` never asserts in this mode.
- R7: After each descriptor is fetched, the table pointer advances by 12 in two-address mode or by 8 in single-cycle I/O mode.
- R8: A descriptor with a byte count of zero produces no data-port cycles. It still counts as one completed block.
- R9: The block counter decreases by one per completed block. When it reaches zero, `done` pulses for exactly one clock, `chan_en` clears, and the channel returns to idle.
- R10: Enabling with a block counter of zero pulses `done` without any table reads. The pointer is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select (0 pointer, 1 block count, 2 control) |
| cfg_wdata | input | AW | Configuration write data |
| tbl_rd_en | output | 1 | Descriptor table read strobe |
| tbl_addr | output | AW | Descriptor table byte address |
| tbl_rdata | input | 8 | Table read data, valid the cycle after the strobe |
| mem_rd_en | output | 1 | Data read strobe |
| mem_wr_en | output | 1 | Data write strobe (two-address mode) |
| mem_addr | output | AW | Data port byte address |
| mem_wdata | output | 8 | Data write byte |
| mem_rdata | input | 8 | Data read byte, valid the cycle after the strobe |
| io_wr_en | output | 1 | I/O write strobe (single-cycle I/O mode) |
| io_wdata | output | 8 | I/O write byte |
| chan_en | output | 1 | Channel enable bit |
| chan_busy | output | 1 | Sequencer not idle |
| start_err | output | 1 | Last start attempt was rejected for an odd pointer |
| done | output | 1 | One-cycle completion pulse |
| tbl_ptr | output | AW | Current table pointer |
| blocks_left | output | CW | Remaining block count |

## Verification
A corrupted fetch counter or byte assembler shows up as a wrong source or destination address, or as wrong data, on the very first data-port write of the affected block. A comparison against the predicted write stream therefore catches it within a dozen cycles. A bad pointer step or block decrement shows up only at the end of a run, in the final `tbl_ptr` value, the number of table reads, or a missing or early `done`. For that reason every run ends with those three observations, and runs mix zero-count descriptors with multi-byte counts whose middle byte is nonzero.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_SRC,
    ST_FETCH_DST,
    ST_FETCH_CNT,
    ST_XFER,
    ST_NEXT,
    ST_DONE
  } chain_st_t;

  localparam int          PARAM_W    = 24;  // every descriptor field
  localparam int          SLOT_BYTES = 4;
  localparam logic [1:0]  CFG_PTR    = 2'd0;
  localparam logic [1:0]  CFG_BLK    = 2'd1;
  localparam logic [1:0]  CFG_CTL    = 2'd2;
endpackage

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
  import dma_chain_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [AW-1:0] wr_data,
  input  logic          busy,
  input  logic          ptr_adv,
  input  logic          blk_dec,
  input  logic          clr_en,
  output logic [AW-1:0] ptr_q,
  output logic [CW-1:0] blk_q,
  output logic          io_mode_q,
  output logic          en_q,
  output logic          err_q
);
  localparam logic [AW-1:0] STEP_TWO = AW'(3 * SLOT_BYTES);
  localparam logic [AW-1:0] STEP_IO  = AW'(2 * SLOT_BYTES);

  logic [AW-1:0] ptr_n;
  logic [CW-1:0] blk_n;
  logic          io_mode_n, en_n, err_n, locked;

  assign locked = en_q | busy;

  always_comb begin
    ptr_n     = ptr_q;
    blk_n     = blk_q;
    io_mode_n = io_mode_q;
    en_n      = en_q;
    err_n     = err_q;
    if (wr_en && !locked) begin
      case (wr_addr)
        CFG_PTR: ptr_n = wr_data;
        CFG_BLK: blk_n = CW'(wr_data);
        CFG_CTL: begin
          io_mode_n = wr_data[1];
          if (wr_data[0]) begin
            if (ptr_q[0]) begin
              err_n = 1'b1;
            end else begin
              en_n  = 1'b1;
              err_n = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
    if (ptr_adv) ptr_n = ptr_q + (io_mode_q ? STEP_IO : STEP_TWO);
    if (blk_dec) blk_n = blk_q - CW'(1);
    if (clr_en)  en_n  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      blk_q     <= '0;
      io_mode_q <= 1'b0;
      en_q      <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      ptr_q     <= ptr_n;
      blk_q     <= blk_n;
      io_mode_q <= io_mode_n;
      en_q      <= en_n;
      err_q     <= err_n;
    end
  end

  // R2: an odd pointer never enables the channel
  a_r2_odd_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !locked && wr_addr == CFG_CTL && wr_data[0] && ptr_q[0])
      |=> (err_q && !en_q));
  // R1: configuration is frozen while the channel runs
  a_r1_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !ptr_adv) |=> $stable(ptr_q));
  // R7: pointer steps by one descriptor
  a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_adv |=> ((ptr_q - $past(ptr_q)) == (io_mode_q ? STEP_IO : STEP_TWO)));
endmodule

// File: rtl/dma_chain_mover.sv
module dma_chain_mover #(
  parameter int AW = 24,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [CW-1:0] cnt_in,
  input  logic          active,
  input  logic          io_mode,
  input  logic [7:0]    mem_rdata,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          io_wr_en,
  output logic [7:0]    io_wdata,
  output logic          last
);
  logic [AW-1:0] src_q, src_n, dst_q, dst_n;
  logic [CW-1:0] rem_q, rem_n;
  logic          wph_q, wph_n;   // 0: read beat, 1: write beat

  assign mem_rd_en = active && !wph_q;
  assign mem_wr_en = active &&  wph_q && !io_mode;
  assign io_wr_en  = active &&  wph_q &&  io_mode;
  assign mem_addr  = (wph_q && !io_mode) ? dst_q : src_q;
  assign mem_wdata = mem_rdata;
  assign io_wdata  = mem_rdata;
  assign last      = active && wph_q && (rem_q == CW'(1));

  always_comb begin
    src_n = src_q;
    dst_n = dst_q;
    rem_n = rem_q;
    wph_n = wph_q;
    if (load) begin
      src_n = src_in;
      dst_n = dst_in;
      rem_n = cnt_in;
      wph_n = 1'b0;
    end else if (active) begin
      if (!wph_q) begin
        wph_n = 1'b1;
      end else begin
        wph_n = 1'b0;
        src_n = src_q + AW'(1);
        dst_n = dst_q + AW'(1);
        rem_n = rem_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      rem_q <= '0;
      wph_q <= 1'b0;
    end else begin
      src_q <= src_n;
      dst_q <= dst_n;
      rem_q <= rem_n;
      wph_q <= wph_n;
    end
  end

  // R5: every write beat follows a read beat
  a_r5_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(mem_rd_en));
  // R6: no memory write in single-cycle I/O mode
  a_r6_io_no_memwr: assert property (@(posedge clk) disable iff (!rst_n)
    io_mode |-> !mem_wr_en);
  // R8: never a data read with nothing left to move
  a_r8_no_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (rem_q != '0));
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import dma_chain_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          io_mode,
  input  logic [AW-1:0] ptr,
  input  logic [CW-1:0] blk,
  input  logic [7:0]    tbl_rdata,
  input  logic          mv_last,
  output logic          tbl_rd_en,
  output logic [AW-1:0] tbl_addr,
  output logic          ptr_adv,
  output logic          blk_dec,
  output logic          clr_en,
  output logic          done,
  output logic          busy,
  output logic          mv_load,
  output logic          mv_active,
  output logic [AW-1:0] mv_src,
  output logic [AW-1:0] mv_dst,
  output logic [CW-1:0] mv_cnt
);
  localparam int          BI_W     = $clog2(SLOT_BYTES);
  localparam logic [BI_W-1:0] BI_LAST = BI_W'(SLOT_BYTES - 1);

  chain_st_t         st_q, st_n;
  logic [BI_W-1:0]   bi_q, bi_n;
  logic [15:0]       asm_q, asm_n;
  logic [AW-1:0]     src_q, src_n, dst_q, dst_n, slot_off;
  logic [PARAM_W-1:0] word;
  logic              fetching, slot_end;

  assign word     = {tbl_rdata, asm_q};
  assign fetching = (st_q == ST_FETCH_SRC) || (st_q == ST_FETCH_DST) ||
                    (st_q == ST_FETCH_CNT);
  assign slot_end = fetching && (bi_q == BI_LAST);

  always_comb begin
    case (st_q)
      ST_FETCH_DST: slot_off = AW'(SLOT_BYTES);
      ST_FETCH_CNT: slot_off = io_mode ? AW'(SLOT_BYTES) : AW'(2 * SLOT_BYTES);
      default:      slot_off = '0;
    endcase
  end

  assign tbl_rd_en = fetching && (bi_q < BI_W'(3));
  assign tbl_addr  = ptr + slot_off + AW'(bi_q);
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_DONE);
  assign clr_en    = (st_q == ST_DONE);
  assign blk_dec   = (st_q == ST_NEXT);
  assign mv_active = (st_q == ST_XFER);
  assign ptr_adv   = slot_end && (st_q == ST_FETCH_CNT);
  assign mv_load   = ptr_adv;
  assign mv_src    = src_q;
  assign mv_dst    = dst_q;
  assign mv_cnt    = CW'(word);

  always_comb begin
    st_n  = st_q;
    bi_n  = bi_q;
    asm_n = asm_q;
    src_n = src_q;
    dst_n = dst_q;
    if (fetching) begin
      bi_n = bi_q + BI_W'(1);
      if (bi_q == BI_W'(1)) asm_n[7:0]  = tbl_rdata;
      if (bi_q == BI_W'(2)) asm_n[15:8] = tbl_rdata;
    end
    case (st_q)
      ST_IDLE: begin
        bi_n = '0;
        if (en) st_n = (blk == '0) ? ST_DONE : ST_FETCH_SRC;
      end
      ST_FETCH_SRC: if (slot_end) begin
        src_n = AW'(word);
        bi_n  = '0;
        st_n  = io_mode ? ST_FETCH_CNT : ST_FETCH_DST;
      end
      ST_FETCH_DST: if (slot_end) begin
        dst_n = AW'(word);
        bi_n  = '0;
        st_n  = ST_FETCH_CNT;
      end
      ST_FETCH_CNT: if (slot_end) begin
        bi_n = '0;
        st_n = (word == '0) ? ST_NEXT : ST_XFER;
      end
      ST_XFER:  if (mv_last) st_n = ST_NEXT;
      ST_NEXT: begin
        bi_n = '0;
        st_n = (blk == CW'(1)) ? ST_DONE : ST_FETCH_SRC;
      end
      ST_DONE:  st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      bi_q  <= '0;
      asm_q <= '0;
      src_q <= '0;
      dst_q <= '0;
    end else begin
      st_q  <= st_n;
      bi_q  <= bi_n;
      asm_q <= asm_n;
      src_q <= src_n;
      dst_q <= dst_n;
    end
  end

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: completion only with no blocks left
  a_r9_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (blk == '0));
  // R3: table reads stay inside the current descriptor
  a_r3_tbl_window: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_en |-> ((tbl_addr - ptr) < (io_mode ? AW'(2 * SLOT_BYTES) : AW'(3 * SLOT_BYTES))));
endmodule

// File: rtl/chain_dma_top.sv
module chain_dma_top #(
  parameter int AW = 24,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_en,
  input  logic [1:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic          tbl_rd_en,
  output logic [AW-1:0] tbl_addr,
  input  logic [7:0]    tbl_rdata,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          io_wr_en,
  output logic [7:0]    io_wdata,
  output logic          chan_en,
  output logic          chan_busy,
  output logic          start_err,
  output logic          done,
  output logic [AW-1:0] tbl_ptr,
  output logic [CW-1:0] blocks_left
);
  logic          io_mode, ptr_adv, blk_dec, clr_en;
  logic          mv_load, mv_active, mv_last;
  logic [AW-1:0] mv_src, mv_dst;
  logic [CW-1:0] mv_cnt;

  dma_chain_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .busy(chan_busy), .ptr_adv(ptr_adv), .blk_dec(blk_dec), .clr_en(clr_en),
    .ptr_q(tbl_ptr), .blk_q(blocks_left), .io_mode_q(io_mode),
    .en_q(chan_en), .err_q(start_err)
  );

  dma_chain_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .en(chan_en), .io_mode(io_mode), .ptr(tbl_ptr), .blk(blocks_left),
    .tbl_rdata(tbl_rdata), .mv_last(mv_last),
    .tbl_rd_en(tbl_rd_en), .tbl_addr(tbl_addr),
    .ptr_adv(ptr_adv), .blk_dec(blk_dec), .clr_en(clr_en),
    .done(done), .busy(chan_busy),
    .mv_load(mv_load), .mv_active(mv_active),
    .mv_src(mv_src), .mv_dst(mv_dst), .mv_cnt(mv_cnt)
  );

  dma_chain_mover #(.AW(AW), .CW(CW)) u_mover (
    .clk(clk), .rst_n(rst_n),
    .load(mv_load), .src_in(mv_src), .dst_in(mv_dst), .cnt_in(mv_cnt),
    .active(mv_active), .io_mode(io_mode), .mem_rdata(mem_rdata),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .io_wr_en(io_wr_en), .io_wdata(io_wdata),
    .last(mv_last)
  );
endmodule

// File: tb/tb_chain_dma_top.sv
module tb_chain_dma_top;
  localparam int AW = 24;
  localparam int CW = 24;

  typedef struct packed {
    logic          io;
    logic [AW-1:0] addr;
    logic [7:0]    data;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr_en;
  logic [1:0]    cfg_addr;
  logic [AW-1:0] cfg_wdata;
  logic          tbl_rd_en, mem_rd_en, mem_wr_en, io_wr_en;
  logic [AW-1:0] tbl_addr, mem_addr, tbl_ptr;
  logic [7:0]    tbl_rdata, mem_rdata, mem_wdata, io_wdata;
  logic          chan_en, chan_busy, start_err, done;
  logic [CW-1:0] blocks_left;

  logic [7:0] pmem [4096];
  exp_t       expq[$];
  int checks = 0, errors = 0;
  int done_cnt = 0, rd_cnt = 0;
  logic prev_done = 1'b0;

  always #2 clk = ~clk;

  chain_dma_top #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tbl_rd_en(tbl_rd_en), .tbl_addr(tbl_addr),
    .tbl_rdata(tbl_rdata), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .io_wr_en(io_wr_en), .io_wdata(io_wdata), .chan_en(chan_en),
    .chan_busy(chan_busy), .start_err(start_err), .done(done),
    .tbl_ptr(tbl_ptr), .blocks_left(blocks_left)
  );

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    logic [11:0] s;
    s = a[11:0] * 12'd7 + 12'd3;
    return s[7:0] ^ {4'h0, a[11:8]};
  endfunction

  // memory models, one-cycle read latency
  always @(posedge clk) begin
    if (tbl_rd_en) tbl_rdata <= pmem[tbl_addr[11:0]];
    if (mem_rd_en) mem_rdata <= pat(mem_addr);
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop and done-pulse width
  always @(negedge clk) begin
    if (rst_n) begin
      if (tbl_rd_en) rd_cnt++;
      if (done) done_cnt++;
      if (done && prev_done) check(1'b0, "R9 done wider than one clock", 32'd1, 32'd0);
      prev_done = done;
      if (mem_wr_en || io_wr_en) begin
        if (expq.size() == 0) begin
          check(1'b0, "R5/R6 unexpected data write", {8'h0, mem_addr}, 32'h0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          if (e.io) begin
            check(io_wr_en && !mem_wr_en && io_wdata == e.data,
                  "R6 io write data", {23'h0, mem_wr_en, io_wdata}, {24'h0, e.data});
          end else begin
            check(mem_wr_en && mem_addr == e.addr && mem_wdata == e.data,
                  "R5 memory write addr/data", {mem_addr, mem_wdata}, {e.addr, e.data});
          end
        end
      end
    end
  end

  task automatic cfg(input logic [1:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic put24(input int a, input logic [23:0] v);
    pmem[a] = v[7:0]; pmem[a+1] = v[15:8]; pmem[a+2] = v[23:16]; pmem[a+3] = 8'hEE;
  endtask

  task automatic expect_block(input bit io, input logic [AW-1:0] s,
                              input logic [AW-1:0] d, input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.io = io; e.addr = d + AW'(i); e.data = pat(s + AW'(i));
      expq.push_back(e);
    end
  endtask

  task automatic wait_done(input string req);
    int base, n;
    base = done_cnt; n = 0;
    while (done_cnt == base && n < 20000) begin
      @(negedge clk); n++;
    end
    check(done_cnt == base + 1, req, done_cnt - base, 1);
    @(negedge clk); @(negedge clk);
    check(!chan_en && !chan_busy, "R9 enable cleared and idle",
          {chan_en, chan_busy}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rd0;
    for (int i = 0; i < 4096; i++) pmem[i] = 8'h00;
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(!chan_en && !chan_busy && !start_err && !done, "R9 reset outputs idle",
          {chan_en, chan_busy, start_err, done}, 0);
    check(tbl_ptr == 0 && blocks_left == 0, "R1 reset registers zero",
          {tbl_ptr, 8'h0}, 0);

    // R2: odd pointer rejected
    cfg(2'd0, 24'h0000C1);
    cfg(2'd1, 24'd2);
    check(tbl_ptr == 24'h0000C1 && blocks_left == 24'd2, "R1 register load",
          {tbl_ptr, blocks_left[7:0]}, {24'h0000C1, 8'd2});
    rd0 = rd_cnt;
    cfg(2'd2, 24'h1);
    repeat (20) @(negedge clk);
    check(start_err && !chan_en && !chan_busy, "R2 odd pointer rejected",
          {start_err, chan_en, chan_busy}, 3'b100);
    check(rd_cnt == rd0, "R2 no table reads after rejection", rd_cnt - rd0, 0);

    // two-address run: three descriptors, middle one empty
    put24(12'h040, 24'h120100); put24(12'h044, 24'h340800); put24(12'h048, 24'd5);
    put24(12'h04C, 24'h000200); put24(12'h050, 24'h000900); put24(12'h054, 24'd0);
    put24(12'h058, 24'h000300); put24(12'h05C, 24'h560A00); put24(12'h060, 24'd3);
    expect_block(1'b0, 24'h120100, 24'h340800, 5);
    expect_block(1'b0, 24'h000300, 24'h560A00, 3);
    cfg(2'd0, 24'h000040);
    cfg(2'd1, 24'd3);
    rd0 = rd_cnt;
    cfg(2'd2, 24'h1);
    check(chan_en && !start_err, "R2 even pointer starts and clears error",
          {chan_en, start_err}, 2'b10);
    repeat (4) @(negedge clk);
    cfg(2'd0, 24'h000777);   // R1: ignored while running
    cfg(2'd1, 24'd9);
    wait_done("R9 done after two-address run");
    check(tbl_ptr == 24'h000064, "R7 pointer advanced 12 per descriptor",
          tbl_ptr, 24'h000064);
    check(blocks_left == 0, "R1 busy writes ignored, R9 counter reaches zero",
          blocks_left, 0);
    check(rd_cnt - rd0 == 27, "R3 nine table reads per descriptor", rd_cnt - rd0, 27);
    check(expq.size() == 0, "R5 R8 all expected writes seen, none for empty block",
          expq.size(), 0);

    // single-cycle I/O run, 258-byte block exercises the middle count byte
    put24(12'h0A0, 24'h000400); put24(12'h0A4, 24'h000102);
    put24(12'h0A8, 24'h780600); put24(12'h0AC, 24'd2);
    expect_block(1'b1, 24'h000400, 24'h0, 258);
    expect_block(1'b1, 24'h780600, 24'h0, 2);
    cfg(2'd0, 24'h0000A0);
    cfg(2'd1, 24'd2);
    rd0 = rd_cnt;
    cfg(2'd2, 24'h3);
    wait_done("R9 done after I/O run");
    check(tbl_ptr == 24'h0000B0, "R7 pointer advanced 8 per descriptor",
          tbl_ptr, 24'h0000B0);
    check(rd_cnt - rd0 == 12, "R4 six table reads per descriptor", rd_cnt - rd0, 12);
    check(expq.size() == 0, "R6 all I/O writes seen", expq.size(), 0);

    // R10: zero block count
    cfg(2'd1, 24'd0);
    rd0 = rd_cnt;
    cfg(2'd2, 24'h1);
    wait_done("R10 done with zero blocks");
    check(rd_cnt == rd0, "R10 no table reads", rd_cnt - rd0, 0);
    check(tbl_ptr == 24'h0000B0, "R10 pointer unchanged", tbl_ptr, 24'h0000B0);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule